// File: doc/BRIEF.md
# Banked Producer/Consumer Hand-off Buffer

This block places a ring of equal-size RAM banks between two independent state machines, a producer that fills data and a consumer that uses it, so that both can work at the same time on different banks. The producer side always sees the bank at the tail of the ring and the consumer side always sees the bank at the head. Each side has its own random-access read and write port into its current bank. With two banks this is classic double buffering: one bank is filled while the other is drained.

Banks change owner one whole bank at a time. The producer issues a push when its bank is ready, which hands that bank to the consumer. The consumer issues a pop when it is finished, which returns the bank to the producer side. A full flag tells the producer to stall and an empty flag tells the consumer to stall. A sticky error flag records any push or pop that was refused.

Top module: `bank_ring_buffer`

## Requirements
- R1: After reset the empty flag is 1, the full flag is 0 and the error flag is 0, and both the head and the tail select bank 0.
- R2: An accepted push moves the tail to the next bank (bank NUM_BANKS-1 wraps to bank 0) and raises occupancy by one.
- R3: An accepted pop moves the head to the next bank with the same wrap and lowers occupancy by one.
- R4: The full flag is 1 exactly when occupancy equals NUM_BANKS.
- R5: The empty flag is 1 exactly when occupancy is 0.
- R6: Producer reads and writes go to the bank selected by the tail; consumer reads and writes go to the bank selected by the head.
- R7: When an accepted push and an accepted pop fall in the same cycle, occupancy and both flags stay as they were while head and tail both advance.
- R8: A push while full, or a pop while empty, is refused (no index or occupancy change) and sets the error flag, which then stays 1 until reset. Legality is judged on the occupancy at the start of the cycle.
- R9: A read presents its data on the read-data output one clock after the read enable and address are sampled; the output holds its value in cycles without an accepted read.
- R10: Producer reads and writes are ignored while full, and consumer reads and writes are ignored while empty, so neither side touches a bank it does not own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| prod_push | input | 1 | Hand the tail bank to the consumer side |
| prod_we | input | 1 | Producer write enable |
| prod_re | input | 1 | Producer read enable |
| prod_addr | input | ADDR_W | Word address inside the tail bank |
| prod_wdata | input | DATA_W | Producer write data |
| prod_rdata | output | DATA_W | Producer read data, one cycle after the read |
| cons_pop | input | 1 | Return the head bank to the producer side |
| cons_we | input | 1 | Consumer write enable |
| cons_re | input | 1 | Consumer read enable |
| cons_addr | input | ADDR_W | Word address inside the head bank |
| cons_wdata | input | DATA_W | Consumer write data |
| cons_rdata | output | DATA_W | Consumer read data, one cycle after the read |
| full | output | 1 | All banks are held by the consumer side |
| empty | output | 1 | No bank is held by the consumer side |
| err | output | 1 | Sticky flag for a refused push or pop |

## Verification
Flags and the error bit come from registers updated on the clock edge that samples push or pop, so they are due one edge after the command; read data is due one edge after the read enable. The bench drives every input on a falling edge, lets exactly one rising edge pass, and samples flags and read data on the next falling edge. Read results go through a scoreboard whose monitor compares at the falling edge that follows the edge at which the read was registered, and refused or ignored operations are followed by reads or flag checks that would expose any change they made.

// File: rtl/bank_ring_pkg.sv
// Shared types for the banked hand-off buffer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package bank_ring_pkg;

    // How occupancy moves in one cycle.
    typedef enum logic [1:0] {
        OCC_HOLD = 2'd0,
        OCC_UP   = 2'd1,
        OCC_DOWN = 2'd2
    } occ_step_t;

endpackage

// File: rtl/ring_ctrl.sv
// Ring control: head, tail and occupancy of the bank ring, plus the
// sticky error flag. Push/pop legality is judged on the occupancy held
// at the start of the cycle. Assumes NUM_BANKS >= 1.
module ring_ctrl
    import bank_ring_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int IDX_W     = 1,
    parameter int CNT_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] occ,
    output logic             full,
    output logic             empty,
    output logic             err
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BANKS - 1);
    localparam logic [CNT_W-1:0] MAX_OCC  = CNT_W'(NUM_BANKS);

    logic      push_ok;
    logic      pop_ok;
    occ_step_t step;

    // Status from the registered occupancy.
    always_comb begin
        full  = (occ == MAX_OCC);
        empty = (occ == '0);
    end

    // Accept commands only when the current occupancy allows them.
    always_comb begin
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        unique case ({push_ok, pop_ok})
            2'b10:   step = OCC_UP;
            2'b01:   step = OCC_DOWN;
            default: step = OCC_HOLD;
        endcase
    end

    // Advance the tail on an accepted push.
    always_ff @(posedge clk) begin
        if (!rst_n)       tail <= '0;
        else if (push_ok) tail <= (tail == LAST_IDX) ? '0 : tail + 1'b1;
    end

    // Advance the head on an accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n)      head <= '0;
        else if (pop_ok) head <= (head == LAST_IDX) ? '0 : head + 1'b1;
    end

    // Track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else begin
            case (step)
                OCC_UP:   occ <= occ + 1'b1;
                OCC_DOWN: occ <= occ - 1'b1;
                default:  occ <= occ;
            endcase
        end
    end

    // Latch any refused command until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  err <= 1'b0;
        else if ((push && full) || (pop && empty))   err <= 1'b1;
    end

endmodule

// File: rtl/bank_ram.sv
// One bank: single-port storage with a combinational read path. The
// registered read stage lives in the top, so a bank's content can be
// read by whichever side owns it. Storage is not reset.
module bank_ram #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write one word.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Present the addressed word.
    assign rdata = mem[addr];

endmodule

// File: rtl/bank_ring_buffer.sv
// Banked producer/consumer hand-off buffer. The producer port maps onto
// the tail bank, the consumer port onto the head bank. Ownership moves a
// whole bank per push/pop. Assumes head and tail only coincide when the
// ring is empty (producer owns) or full (consumer owns).
module bank_ring_buffer
    import bank_ring_pkg::*;
#(
    parameter int NUM_BANKS  = 2,
    parameter int BANK_DEPTH = 16,
    parameter int DATA_W     = 16,
    localparam int ADDR_W    = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prod_push,
    input  logic              prod_we,
    input  logic              prod_re,
    input  logic [ADDR_W-1:0] prod_addr,
    input  logic [DATA_W-1:0] prod_wdata,
    output logic [DATA_W-1:0] prod_rdata,
    input  logic              cons_pop,
    input  logic              cons_we,
    input  logic              cons_re,
    input  logic [ADDR_W-1:0] cons_addr,
    input  logic [DATA_W-1:0] cons_wdata,
    output logic [DATA_W-1:0] cons_rdata,
    output logic              full,
    output logic              empty,
    output logic              err
);

    localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int CNT_W = $clog2(NUM_BANKS + 1);

    logic [IDX_W-1:0]  head;
    logic [IDX_W-1:0]  tail;
    logic [CNT_W-1:0]  occ;
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];
    logic              prod_live;
    logic              cons_live;

    ring_ctrl #(
        .NUM_BANKS (NUM_BANKS),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (prod_push),
        .pop   (cons_pop),
        .head  (head),
        .tail  (tail),
        .occ   (occ),
        .full  (full),
        .empty (empty),
        .err   (err)
    );

    // A side may touch its bank only while it owns one.
    always_comb begin
        prod_live = !full;
        cons_live = !empty;
    end

    // One bank per ring slot, its port steered to the owning side.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic              own_p;
        logic              own_c;
        logic              we_b;
        logic [ADDR_W-1:0] addr_b;
        logic [DATA_W-1:0] wdata_b;

        // Steer address, data and write enable to this bank.
        always_comb begin
            own_p   = prod_live && (tail == IDX_W'(b));
            own_c   = cons_live && (head == IDX_W'(b));
            addr_b  = own_p ? prod_addr  : cons_addr;
            wdata_b = own_p ? prod_wdata : cons_wdata;
            we_b    = (own_p && prod_we) || (own_c && cons_we);
        end

        bank_ram #(
            .DEPTH  (BANK_DEPTH),
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W)
        ) u_ram (
            .clk   (clk),
            .we    (we_b),
            .addr  (addr_b),
            .wdata (wdata_b),
            .rdata (bank_rd[b])
        );
    end

    // Register producer read data from the tail bank.
    always_ff @(posedge clk) begin
        if (!rst_n)                     prod_rdata <= '0;
        else if (prod_re && prod_live)  prod_rdata <= bank_rd[tail];
    end

    // Register consumer read data from the head bank.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cons_rdata <= '0;
        else if (cons_re && cons_live)  cons_rdata <= bank_rd[head];
    end

endmodule

// File: rtl/bank_ring_checker.sv
// Temporal properties for bank_ring_buffer, attached through bind.
module bank_ring_checker #(
    parameter int NUM_BANKS = 2,
    parameter int CNT_W     = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push,
    input logic             pop,
    input logic             full,
    input logic             empty,
    input logic             err,
    input logic [CNT_W-1:0] occ
);

    p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    p_occ_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(NUM_BANKS));

    p_push_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && empty) |=> !empty);

    p_pop_drains_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && full) |=> !full);

    p_pair_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty) |=> ($stable(occ) && $stable(full) && $stable(empty)));

    p_bad_push_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> err);

    p_bad_pop_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> err);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    p_bad_push_keeps_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> full);

endmodule

bind bank_ring_buffer bank_ring_checker #(
    .NUM_BANKS (NUM_BANKS),
    .CNT_W     (CNT_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (prod_push),
    .pop   (cons_pop),
    .full  (full),
    .empty (empty),
    .err   (err),
    .occ   (occ)
);

// File: tb/sim_bank_ring_buffer.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares
// them one edge later; flags are compared directly after each operation.
module sim_bank_ring_buffer;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 2;
    localparam int DEPTH = 16;
    localparam int DW = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prod_push = 1'b0, prod_we = 1'b0, prod_re = 1'b0;
    logic [AW-1:0] prod_addr = '0;
    logic [DW-1:0] prod_wdata = '0;
    logic [DW-1:0] prod_rdata;
    logic          cons_pop = 1'b0, cons_we = 1'b0, cons_re = 1'b0;
    logic [AW-1:0] cons_addr = '0;
    logic [DW-1:0] cons_wdata = '0;
    logic [DW-1:0] cons_rdata;
    logic          full, empty, err;

    int n_checks = 0;
    int n_fail = 0;

    logic [DW-1:0] p_exp_q[$];
    string         p_tag_q[$];
    logic [DW-1:0] c_exp_q[$];
    string         c_tag_q[$];
    logic          p_issue = 1'b0, c_issue = 1'b0;
    logic          p_pend = 1'b0, c_pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_ring_buffer #(.NUM_BANKS(NB), .BANK_DEPTH(DEPTH), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .prod_push(prod_push), .prod_we(prod_we), .prod_re(prod_re),
        .prod_addr(prod_addr), .prod_wdata(prod_wdata), .prod_rdata(prod_rdata),
        .cons_pop(cons_pop), .cons_we(cons_we), .cons_re(cons_re),
        .cons_addr(cons_addr), .cons_wdata(cons_wdata), .cons_rdata(cons_rdata),
        .full(full), .empty(empty), .err(err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reads registered at a rising edge are due at the next falling edge.
    always @(posedge clk) begin
        p_pend <= p_issue;
        c_pend <= c_issue;
    end

    always @(negedge clk) begin
        if (p_pend && p_exp_q.size() > 0) check(p_tag_q.pop_front(), prod_rdata, p_exp_q.pop_front());
        if (c_pend && c_exp_q.size() > 0) check(c_tag_q.pop_front(), cons_rdata, c_exp_q.pop_front());
    end

    task automatic idle();
        prod_push = 0; prod_we = 0; prod_re = 0;
        cons_pop = 0; cons_we = 0; cons_re = 0;
        p_issue = 0; c_issue = 0;
    endtask

    // Each operation holds for exactly one rising edge.
    task automatic finish_op();
        @(negedge clk);
        idle();
    endtask

    task automatic pwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); prod_we = 1; prod_addr = a; prod_wdata = d;
        finish_op();
    endtask

    task automatic cwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); cons_we = 1; cons_addr = a; cons_wdata = d;
        finish_op();
    endtask

    task automatic pread(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        @(negedge clk); prod_re = 1; prod_addr = a; p_issue = 1;
        p_exp_q.push_back(e); p_tag_q.push_back(tag);
        finish_op();
    endtask

    task automatic cread(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        @(negedge clk); cons_re = 1; cons_addr = a; c_issue = 1;
        c_exp_q.push_back(e); c_tag_q.push_back(tag);
        finish_op();
    endtask

    task automatic cmd(input logic pu, input logic po);
        @(negedge clk); prod_push = pu; cons_pop = po;
        finish_op();
    endtask

    task automatic flags(input string tag, input logic f, input logic e, input logic r);
        check({tag, " full"}, full, f);
        check({tag, " empty"}, empty, e);
        check({tag, " err"}, err, r);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; idle();
        @(negedge clk);
        @(negedge clk); rst_n = 1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        idle();
        do_reset();
        flags("R1 reset", 0, 1, 0);

        // Fill bank 0 from the producer side, read back with latency.
        for (int i = 0; i < 4; i++) pwrite(AW'(i), DW'(16'h1000 + i));
        pread(2, 16'h1002, "R9 producer read latency");

        cmd(1, 0);
        flags("R2 after first push", 0, 0, 0);

        // Producer now on bank 1, consumer on bank 0.
        for (int i = 0; i < 4; i++) pwrite(AW'(i), DW'(16'h2000 + i));
        pread(1, 16'h2001, "R6 producer at tail bank");
        for (int i = 0; i < 4; i++) cread(AW'(i), DW'(16'h1000 + i), "R6 consumer at head bank");
        cwrite(5, 16'h5555);
        cread(5, 16'h5555, "R6 consumer write");

        cmd(1, 0);
        flags("R4 full after second push", 1, 0, 0);

        // Producer activity while full touches nothing.
        pwrite(0, 16'hDEAD);
        cread(0, 16'h1000, "R10 producer write ignored while full");
        pread(3, 16'h2001, "R10 producer read ignored while full");

        cmd(1, 0);
        flags("R8 push while full", 1, 0, 1);

        cmd(0, 1);
        flags("R3 after pop", 0, 0, 1);
        cread(2, 16'h2002, "R3 head moved to bank 1");

        pwrite(0, 16'h00A0);
        cmd(1, 1);
        flags("R7 push and pop together", 0, 0, 1);
        cread(0, 16'h00A0, "R7 head wrapped to bank 0");
        pread(3, 16'h2003, "R7 tail moved to bank 1");

        cmd(0, 1);
        flags("R5 empty after last pop", 0, 1, 1);
        cwrite(0, 16'hBEEF);
        cread(0, 16'h00A0, "R10 consumer read ignored while empty");
        cmd(1, 0);
        cread(0, 16'h2000, "R10 consumer write ignored while empty");

        do_reset();
        flags("R1 second reset", 0, 1, 0);
        cmd(0, 1);
        flags("R8 pop while empty", 0, 1, 1);
        repeat (3) @(negedge clk);
        check("R8 error sticky", err, 1);

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule